// File: doc/BRIEF.md
# Four-bit GPIO Expander Core with Change Interrupt

This block is the register core of a small I/O expander that sits behind a byte-level serial slave. The bit-level bus logic ahead of it delivers three kinds of event. `xfer_start` begins a transaction. `wr_en` with `wr_byte` passes one received byte. `xfer_stop` ends the transaction. A host read request, `rd_en`, returns one byte on `rd_data`, and `rd_valid` marks it.

Four 4-bit registers control four pins: direction, output value, read polarity, and a captured copy of the input pins. Each pin is driven from the output register when its direction bit marks it as an output. Otherwise the pin is left undriven. Input pins pass through a two-stage synchroniser. An active-low interrupt, driven only as a pull-down request, tells the host that an input pin has moved away from the value captured at the last input read.

A control state machine runs the following states:

- `ST_INIT`: runs after any reset until the synchroniser holds valid pin data.
- `ST_IDLE`: no transaction is open.
- `ST_PTR`: waits for the pointer byte.
- `ST_DATA`: waits for the data byte.
- `ST_HOLD`: ignores surplus bytes.

The transitions are:

- INIT→IDLE once the init count expires.
- Any non-INIT state→PTR on a start.
- Any non-INIT state→IDLE on a stop.
- PTR→DATA on a byte.
- DATA→HOLD on a byte, which writes that byte to the selected register.

Top module: `gx_expander`

## Requirements
- R1: After reset the direction register is 4'hF (1 = input), the output register is 4'hF and the polarity register is 4'h0. Every `io_oe` bit is 0, and `int_n` is high while the pins stay still.
- R2: The first byte after a start is the pointer, and its low two bits select the register: 0 input, 1 output, 2 polarity, 3 direction. The next byte writes its low nibble to that register. Any later bytes are ignored until a new start. Start has priority over stop, and stop has priority over a byte.
- R3: A data byte written with pointer 0 changes no register.
- R4: A read request outside `ST_INIT` raises `rd_valid` for the following cycle. In that cycle `rd_data` carries the selected register in bits 3:0, and bits 7:4 are zero.
- R5: Reading pointer 0 returns the synchronised pins XOR the polarity register.
- R6: `io_oe[i]` is the inverse of direction bit i, and `io_out` equals the output register.
- R7: `int_n` goes low two clock edges after an input-direction pin changes to a value that differs from the captured input register.
- R8: A read with pointer 0 captures the synchronised pins. If the pins are still, `int_n` is high right after that edge.
- R9: `int_n` returns high when the pins go back to the captured value, again two edges after the change.
- R10: Pins set as outputs never pull `int_n` low.
- R11: Either `por_n` or `rst_n` low restores the R1 state. Start, stop, byte and read strobes are ignored during the three `ST_INIT` cycles that follow the release of reset.
- R12: The pointer persists across transactions, so a read with no new pointer returns the register selected last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | External reset, active low, asynchronous |
| xfer_start | input | 1 | Transaction start (or repeated start) pulse |
| xfer_stop | input | 1 | Transaction stop pulse |
| wr_en | input | 1 | Received byte valid |
| wr_byte | input | 8 | Received byte |
| rd_en | input | 1 | Host read request |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read byte |
| io_in | input | 4 | Pin input levels |
| io_out | output | 4 | Pin output levels |
| io_oe | output | 4 | Pin drive enables |
| int_n | output | 1 | Interrupt, low = pull down |

## Verification
Read data appears one edge after the request. Register writes show on `io_oe` and `io_out` one edge after the data byte. A pin change reaches `int_n` two edges later, and a capturing read releases `int_n` on the read edge itself. The bench drives inputs just after the falling edge and samples at the next falling edge. A behavioural model, advanced on each rising edge, predicts every output, and the outputs are compared with it every cycle. The directed checks count these latencies explicitly: for R7, `int_n` must still be high after the first edge and low after the second.

// File: rtl/gx_pkg.sv
package gx_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_PTR,
        ST_DATA,
        ST_HOLD
    } gx_state_e;

    localparam logic [1:0] PTR_IN  = 2'd0;
    localparam logic [1:0] PTR_OUT = 2'd1;
    localparam logic [1:0] PTR_POL = 2'd2;
    localparam logic [1:0] PTR_CFG = 2'd3;

endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg[0] <= '0;
                else         stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg[g] <= '0;
                else         stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gx_ctrl.sv
module gx_ctrl
    import gx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_en,
    output gx_state_e         st,
    output logic [1:0]        ptr,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              init_cap
);
    localparam int CW = $clog2(SYNC_STAGES + 1);
    localparam logic [CW-1:0] INIT_LAST = CW'(SYNC_STAGES);

    gx_state_e   st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [1:0]  ptr_q;
    logic        byte_ok;

    assign byte_ok = wr_en && !xfer_start && !xfer_stop;

    // state register, init counter and pointer
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q  <= ST_INIT;
            cnt_q <= '0;
            ptr_q <= PTR_IN;
        end else begin
            st_q <= st_d;
            if (st_q == ST_INIT) cnt_q <= cnt_q + 1'b1;
            if (st_q == ST_PTR && byte_ok) ptr_q <= wr_byte[1:0];
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT: if (cnt_q == INIT_LAST) st_d = ST_IDLE;
            ST_IDLE: begin
                if (xfer_start) st_d = ST_PTR;
            end
            ST_PTR: begin
                if (xfer_start)     st_d = ST_PTR;
                else if (xfer_stop) st_d = ST_IDLE;
                else if (wr_en)     st_d = ST_DATA;
            end
            ST_DATA: begin
                if (xfer_start)     st_d = ST_PTR;
                else if (xfer_stop) st_d = ST_IDLE;
                else if (wr_en)     st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (xfer_start)     st_d = ST_PTR;
                else if (xfer_stop) st_d = ST_IDLE;
            end
            default: st_d = ST_INIT;
        endcase
    end

    // outputs
    always_comb begin
        wr_stb   = 1'b0;
        rd_stb   = 1'b0;
        init_cap = 1'b0;
        unique case (st_q)
            ST_INIT: init_cap = 1'b1;
            ST_IDLE, ST_PTR, ST_HOLD: rd_stb = rd_en;
            ST_DATA: begin
                rd_stb = rd_en;
                wr_stb = byte_ok;
            end
            default: init_cap = 1'b0;
        endcase
    end

    assign st  = st_q;
    assign ptr = ptr_q;
endmodule

// File: rtl/gx_regfile.sv
module gx_regfile
    import gx_pkg::*;
#(
    parameter int NBITS  = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              init_cap,
    input  logic [1:0]        ptr,
    input  logic [NBITS-1:0]  wr_val,
    input  logic [NBITS-1:0]  pins,
    output logic [NBITS-1:0]  cfg,
    output logic [NBITS-1:0]  outr,
    output logic [NBITS-1:0]  pol,
    output logic [NBITS-1:0]  cap,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int PAD = BYTE_W - NBITS;

    logic [NBITS-1:0] sel;

    always_comb begin
        unique case (ptr)
            PTR_IN:  sel = pins ^ pol;
            PTR_OUT: sel = outr;
            PTR_POL: sel = pol;
            PTR_CFG: sel = cfg;
            default: sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cfg  <= '1;
            outr <= '1;
            pol  <= '0;
        end else if (wr_stb) begin
            unique case (ptr)
                PTR_OUT: outr <= wr_val;
                PTR_POL: pol  <= wr_val;
                PTR_CFG: cfg  <= wr_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cap      <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (init_cap || (rd_stb && ptr == PTR_IN)) cap <= pins;
            if (rd_stb) rd_data <= {{PAD{1'b0}}, sel};
        end
    end
endmodule

// File: rtl/gx_irq.sv
module gx_irq #(
    parameter int NBITS = 4
) (
    input  logic [NBITS-1:0] pins,
    input  logic [NBITS-1:0] cap,
    input  logic [NBITS-1:0] cfg,
    output logic             int_n
);
    logic [NBITS-1:0] diff;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign diff[i] = cfg[i] & (pins[i] ^ cap[i]);
    end

    assign int_n = ~|diff;
endmodule

// File: rtl/gx_expander.sv
module gx_expander
    import gx_pkg::*;
#(
    parameter int NBITS       = 4,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [NBITS-1:0]  io_in,
    output logic [NBITS-1:0]  io_out,
    output logic [NBITS-1:0]  io_oe,
    output logic              int_n
);
    logic             arst_n;
    gx_state_e        st_q;
    logic [1:0]       ptr_q;
    logic             wr_stb, rd_stb, init_cap;
    logic [NBITS-1:0] pins_s, cfg_q, out_q, pol_q, cap_q;

    assign arst_n = por_n & rst_n;

    gx_sync #(.W(NBITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .arst_n(arst_n), .d(io_in), .q(pins_s)
    );

    gx_ctrl #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W)) u_ctrl (
        .clk(clk), .arst_n(arst_n),
        .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en),
        .st(st_q), .ptr(ptr_q), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .init_cap(init_cap)
    );

    gx_regfile #(.NBITS(NBITS), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .arst_n(arst_n),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .init_cap(init_cap),
        .ptr(ptr_q), .wr_val(wr_byte[NBITS-1:0]), .pins(pins_s),
        .cfg(cfg_q), .outr(out_q), .pol(pol_q), .cap(cap_q),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    gx_irq #(.NBITS(NBITS)) u_irq (
        .pins(pins_s), .cap(cap_q), .cfg(cfg_q), .int_n(int_n)
    );

    assign io_oe  = ~cfg_q;
    assign io_out = out_q;
endmodule

// File: rtl/gx_expander_chk.sv
module gx_expander_chk
    import gx_pkg::*;
#(
    parameter int NBITS  = 4,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              arst_n,
    input gx_state_e         st,
    input logic [1:0]        ptr,
    input logic              wr_stb,
    input logic [BYTE_W-1:0] wr_byte,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [BYTE_W-1:0] rd_data,
    input logic [NBITS-1:0]  io_oe,
    input logic [NBITS-1:0]  io_out,
    input logic              int_n,
    input logic [NBITS-1:0]  cfg,
    input logic [NBITS-1:0]  outr,
    input logic [NBITS-1:0]  pol
);
    AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_en && st != ST_INIT) |=> rd_valid); // R4
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
        rd_valid |-> (rd_data[BYTE_W-1:NBITS] == '0)); // R4
    AST_CFG_TO_OE: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_stb && ptr == PTR_CFG) |=> (io_oe == ~$past(wr_byte[NBITS-1:0]))); // R6
    AST_OUT_TO_PINS: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_stb && ptr == PTR_OUT) |=> (io_out == $past(wr_byte[NBITS-1:0]))); // R2
    AST_IN_WRITE_NOP: assert property (@(posedge clk) disable iff (!arst_n)
        (wr_stb && ptr == PTR_IN) |=> ($stable(cfg) && $stable(outr) && $stable(pol))); // R3
    AST_INIT_FROZEN: assert property (@(posedge clk) disable iff (!arst_n)
        (st == ST_INIT) |=> ($stable(cfg) && $stable(outr) && $stable(pol))); // R11
    AST_OUTPUTS_NO_IRQ: assert property (@(posedge clk) disable iff (!arst_n)
        (&io_oe) |-> int_n); // R10
endmodule

bind gx_expander gx_expander_chk #(.NBITS(NBITS), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .arst_n(arst_n), .st(st_q), .ptr(ptr_q), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .io_oe(io_oe), .io_out(io_out), .int_n(int_n),
    .cfg(cfg_q), .outr(out_q), .pol(pol_q)
);

// File: tb/gx_expander_tb.sv
module gx_expander_tb;
    localparam int HALF = 10;

    logic       clk = 0;
    logic       por_n = 0, rst_n = 0;
    logic       xfer_start = 0, xfer_stop = 0, wr_en = 0, rd_en = 0;
    logic [7:0] wr_byte = 0;
    logic [3:0] io_in = 4'b1010;
    logic       rd_valid, int_n;
    logic [7:0] rd_data;
    logic [3:0] io_out, io_oe;

    int checks = 0, fails = 0;
    bit done = 0;

    always #HALF clk = ~clk;

    gx_expander u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .int_n(int_n)
    );

    // behavioural reference model
    int   m_phase;   // 0 init,1 idle,2 ptr,3 data,4 hold
    int   m_init;
    int   m_ptr;
    logic [3:0] m_cfg, m_out, m_pol, m_cap;
    logic [3:0] m_pipe [$];
    logic m_rdv;
    logic [7:0] m_rdd;
    bit   m_live = 0;

    function automatic logic [3:0] m_sync();
        return m_pipe[1];
    endfunction

    always @(posedge clk) begin
        logic [3:0] s_old;
        if (!(por_n && rst_n)) begin
            m_phase = 0; m_init = 0; m_ptr = 0;
            m_cfg = 4'hF; m_out = 4'hF; m_pol = 4'h0; m_cap = 4'h0;
            m_pipe = '{4'h0, 4'h0};
            m_rdv = 0; m_rdd = 0;
        end else begin
            s_old = m_sync();
            m_rdv = 0;
            if (m_phase == 0) begin
                m_cap = s_old;
                if (m_init == 2) m_phase = 1;
                m_init++;
            end else begin
                if (rd_en) begin
                    m_rdv = 1;
                    case (m_ptr)
                        0: begin m_rdd = {4'h0, s_old ^ m_pol}; m_cap = s_old; end
                        1: m_rdd = {4'h0, m_out};
                        2: m_rdd = {4'h0, m_pol};
                        default: m_rdd = {4'h0, m_cfg};
                    endcase
                end
                if (xfer_start) m_phase = 2;
                else if (xfer_stop) m_phase = 1;
                else if (wr_en && m_phase == 2) begin m_ptr = int'(wr_byte[1:0]); m_phase = 3; end
                else if (wr_en && m_phase == 3) begin
                    if (m_ptr == 1) m_out = wr_byte[3:0];
                    if (m_ptr == 2) m_pol = wr_byte[3:0];
                    if (m_ptr == 3) m_cfg = wr_byte[3:0];
                    m_phase = 4;
                end
            end
            m_pipe.push_front(io_in);
            void'(m_pipe.pop_back());
        end
        m_live = 1;
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (m_live && por_n && rst_n && !done) begin
            logic exp_int;
            exp_int = ~|((m_sync() ^ m_cap) & m_cfg);
            chk("R6 io_oe", {4'h0, io_oe}, {4'h0, ~m_cfg});
            chk("R2 io_out", {4'h0, io_out}, {4'h0, m_out});
            chk("R7 int_n", {7'h0, int_n}, {7'h0, exp_int});
            chk("R4 rd_valid", {7'h0, rd_valid}, {7'h0, m_rdv});
            if (m_rdv) chk("R4 rd_data", rd_data, m_rdd);
        end
    end

    task automatic step(); @(negedge clk); #1; endtask

    task automatic set_ptr(logic [1:0] p);
        step(); xfer_start = 1;
        step(); xfer_start = 0; wr_en = 1; wr_byte = {6'h0, p};
        step(); wr_en = 0; xfer_stop = 1;
        step(); xfer_stop = 0;
    endtask

    task automatic write_reg(logic [1:0] p, logic [7:0] v);
        step(); xfer_start = 1;
        step(); xfer_start = 0; wr_en = 1; wr_byte = {6'h0, p};
        step(); wr_byte = v;
        step(); wr_en = 0; xfer_stop = 1;
        step(); xfer_stop = 0;
    endtask

    task automatic read_cur(output logic [7:0] d);
        step(); rd_en = 1;
        @(negedge clk); d = rd_data; #1; rd_en = 0;
    endtask

    task automatic read_reg(logic [1:0] p, output logic [7:0] d);
        set_ptr(p);
        read_cur(d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) step();
        por_n = 1; rst_n = 1;
        repeat (5) step();
        // R1 reset state
        chk("R1 oe", {4'h0, io_oe}, 8'h00);
        chk("R1 int_n", {7'h0, int_n}, 8'h01);
        read_reg(2'd3, d); chk("R1 cfg", d, 8'h0F);
        read_reg(2'd1, d); chk("R1 out", d, 8'h0F);
        read_reg(2'd2, d); chk("R1 pol", d, 8'h00);

        // R11: external reset, strobes during init ignored
        write_reg(2'd2, 8'h09);
        step(); rst_n = 0;
        step(); rst_n = 1; xfer_start = 1;
        step(); xfer_start = 0; wr_en = 1; wr_byte = 8'h03;
        step(); wr_byte = 8'h00;
        step(); wr_en = 0;
        read_reg(2'd3, d); chk("R11 cfg after init strobes", d, 8'h0F);
        read_reg(2'd2, d); chk("R11 pol restored", d, 8'h00);

        // R2/R6 write output and direction, surplus byte ignored
        write_reg(2'd1, 8'hF5);
        write_reg(2'd3, 8'h0C);
        chk("R6 oe", {4'h0, io_oe}, 8'h03);
        chk("R6 out", {4'h0, io_out}, 8'h05);
        step(); xfer_start = 1;
        step(); xfer_start = 0; wr_en = 1; wr_byte = 8'h01;
        step(); wr_byte = 8'h06;
        step(); wr_byte = 8'h0A;
        step(); wr_en = 0; xfer_stop = 1;
        step(); xfer_stop = 0;
        chk("R2 surplus byte ignored", {4'h0, io_out}, 8'h06);

        // R3 input write ignored, R5 polarity
        write_reg(2'd0, 8'h03);
        read_reg(2'd0, d); chk("R3 input unaffected", d, 8'h0A);
        write_reg(2'd2, 8'h06);
        read_reg(2'd0, d); chk("R5 inverted read", d, 8'h0C);
        // R12 pointer persists (last pointer 0)
        step(); xfer_start = 1;
        step(); xfer_start = 0; xfer_stop = 1;
        step(); xfer_stop = 0;
        read_cur(d); chk("R12 pointer kept", d, 8'h0C);

        // R7 interrupt latency on input pin 3
        step(); io_in = 4'b0010;
        chk("R7 int after 0 edges", {7'h0, int_n}, 8'h01);
        @(negedge clk); chk("R7 int after 1 edge", {7'h0, int_n}, 8'h01);
        @(negedge clk); chk("R7 int after 2 edges", {7'h0, int_n}, 8'h00);
        // R9 return clears
        #1; io_in = 4'b1010;
        @(negedge clk); @(negedge clk);
        chk("R9 int released", {7'h0, int_n}, 8'h01);
        // R8 read clears
        #1; io_in = 4'b0110;
        repeat (3) @(negedge clk);
        chk("R8 int before read", {7'h0, int_n}, 8'h00);
        read_cur(d);
        chk("R8 int after read", {7'h0, int_n}, 8'h01);
        chk("R8 read value", d, 8'h00);
        // R10 output pins excluded
        step(); io_in = 4'b0101;
        repeat (3) @(negedge clk);
        chk("R10 output pins quiet", {7'h0, int_n}, 8'h01);

        // R11 power-on reset
        step(); por_n = 0;
        step(); por_n = 1;
        repeat (5) step();
        chk("R11 por oe", {4'h0, io_oe}, 8'h00);
        read_reg(2'd1, d); chk("R11 por out", d, 8'h0F);

        repeat (4) step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule